// File: doc/BRIEF.md
# Bi-Quinary Decade Counter with Force-to-Nine

The block is a four-bit counter built from two sections that run on their own. A single toggle stage, the lowest output bit, advances on falling edges of count input A. A divide-by-five stage, the upper three output bits, advances on falling edges of count input B. Connecting the lowest output bit back to input B outside the block turns the pair into a BCD decade counter. Leaving them apart gives a divide-by-2 and a divide-by-5 that can be used separately.

Both count inputs are treated as slow, asynchronous signals. Each passes through a synchronizer on the system clock. A falling-edge detector follows the synchronizer, and the count register updates on the next system clock edge. Two AND-gated control pairs override counting and are checked on every system clock. The zero pair drives all bits to 0000. The nine pair drives them to 1001 and wins over the zero pair. An active-low system reset clears the outputs and the edge history.

Top module: `biquinary_counter`

## Requirements
- R1: A section changes only in response to a falling edge on its own count input. Rising edges, steady levels and edges on the other section's input leave it unchanged.
- R2: Output bit 0 inverts on every falling edge of input A, so it divides A by two.
- R3: Output bits 3..1, read as a 3-bit value, step 0, 1, 2, 3, 4 and back to 0 on successive falling edges of input B. An unused code (5, 6 or 7) returns to 0 on the next step.
- R4: With bit 0 fed back to input B, the 4-bit output (bit 3 most significant) follows BCD 0 through 9 and wraps to 0 on successive falling edges of A.
- R5: When both zero controls are high and the nine pair is not both high, the output becomes 0000 at the next system clock edge.
- R6: When both nine controls are high, the output becomes 1001 at the next system clock edge, whatever the zero controls are.
- R7: When only one input of a control pair is high, that pair has no effect on the output.
- R8: Count-input edges that occur while a force is active are discarded. After the force is released, the output keeps the forced value until a new edge arrives.
- R9: While rst_n is low, the output is 0000.
- R10: A falling edge applied to a count input is visible on the output three system clock edges later, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cnt_a_in | input | 1 | Count input for the toggle stage (bit 0) |
| cnt_b_in | input | 1 | Count input for the divide-by-five stage (bits 3..1) |
| zero_req_a | input | 1 | First input of the force-to-zero pair |
| zero_req_b | input | 1 | Second input of the force-to-zero pair |
| nine_req_a | input | 1 | First input of the force-to-nine pair |
| nine_req_b | input | 1 | Second input of the force-to-nine pair |
| q_out | output | 4 | Count value; bit 0 is the toggle stage, bits 3..1 the divide-by-five stage |

## Verification
The bench runs all sixteen combinations of the four control inputs, each from a count of eight. This catches three faults: a design that ORs a pair instead of ANDing it, one that gives zero priority over nine, and one that disturbs the count when only half a pair is active. A wired BCD run of 25 steps checks the wrap from 9 to 0 twice and the carry out of bit 0 through the external feedback. Separate runs pulse B alone and raise A without dropping it, which exposes a section that follows the wrong input or the wrong edge. The bench also checks latency to the exact cycle, so an extra or missing synchronizer stage shows up. Finally, it pulses A during a force and checks after release, which exposes a design that keeps a stale edge pending.

// File: rtl/bq_pkg.sv
package bq_pkg;

  localparam int QUIN_W = 3;
  localparam logic [QUIN_W-1:0] QUIN_LAST = 3'd4;

  typedef enum logic [1:0] {
    FORCE_NONE = 2'd0,
    FORCE_ZERO = 2'd1,
    FORCE_NINE = 2'd2
  } force_e;

  // Next state of the divide-by-five stage; any code past the last wraps to 0.
  function automatic logic [QUIN_W-1:0] quinary_next(input logic [QUIN_W-1:0] cur);
    if (cur >= QUIN_LAST) return '0;
    return cur + 1'b1;
  endfunction

  // Priority decode of the two AND-gated control pairs; nine wins.
  function automatic force_e force_decode(input logic za, input logic zb,
                                          input logic na, input logic nb);
    if (na && nb) return FORCE_NINE;
    if (za && zb) return FORCE_ZERO;
    return FORCE_NONE;
  endfunction

endpackage

// File: rtl/bq_edge_sync.sv
module bq_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic fall_out
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   hist_q;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sig_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= 1'b0;
    else        hist_q <= sync_q[LAST];
  end

  assign fall_out = hist_q && !sync_q[LAST];

  // R1: a detected fall lasts exactly one system clock
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_out |=> !fall_out);

endmodule

// File: rtl/bq_toggle_stage.sv
module bq_toggle_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic force_clr,
  input  logic force_set,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= 1'b0;
    else if (force_set) q <= 1'b1;
    else if (force_clr) q <= 1'b0;
    else if (step)      q <= ~q;
  end

  // R2
  qa_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !force_set && !force_clr) |=> (q != $past(q)));

  // R1
  qa_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !force_set && !force_clr) |=> $stable(q));

endmodule

// File: rtl/bq_quinary_stage.sv
module bq_quinary_stage
  import bq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              force_clr,
  input  logic              force_set,
  output logic [QUIN_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= '0;
    else if (force_set) q <= QUIN_LAST;
    else if (force_clr) q <= '0;
    else if (step)      q <= quinary_next(q);
  end

  // R3
  quin_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !force_set && !force_clr) |=> (q <= QUIN_LAST));

  // R3
  quin_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !force_set && !force_clr && q == QUIN_LAST) |=> (q == '0));

  // R1
  quin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !force_set && !force_clr) |=> $stable(q));

endmodule

// File: rtl/biquinary_counter.sv
module biquinary_counter
  import bq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_a_in,
  input  logic       cnt_b_in,
  input  logic       zero_req_a,
  input  logic       zero_req_b,
  input  logic       nine_req_a,
  input  logic       nine_req_b,
  output logic [3:0] q_out
);

  logic              fall_a, fall_b;
  logic              force_zero, force_nine, force_any;
  logic              step_a, step_b;
  logic              qa;
  logic [QUIN_W-1:0] quin_q;
  force_e            force_sel;

  bq_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk), .rst_n(rst_n), .sig_in(cnt_a_in), .fall_out(fall_a));

  bq_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk), .rst_n(rst_n), .sig_in(cnt_b_in), .fall_out(fall_b));

  always_comb force_sel = force_decode(zero_req_a, zero_req_b, nine_req_a, nine_req_b);

  assign force_nine = (force_sel == FORCE_NINE);
  assign force_zero = (force_sel == FORCE_ZERO);
  assign force_any  = force_nine || force_zero;
  assign step_a     = fall_a && !force_any;
  assign step_b     = fall_b && !force_any;

  bq_toggle_stage u_toggle (
    .clk(clk), .rst_n(rst_n), .step(step_a),
    .force_clr(force_zero), .force_set(force_nine), .q(qa));

  bq_quinary_stage u_quin (
    .clk(clk), .rst_n(rst_n), .step(step_b),
    .force_clr(force_zero), .force_set(force_nine), .q(quin_q));

  assign q_out = {quin_q, qa};

  // R6
  nine_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nine_req_a && nine_req_b) |=> (q_out == 4'b1001));

  // R5
  zero_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_req_a && zero_req_b && !(nine_req_a && nine_req_b)) |=> (q_out == 4'b0000));

  // R8
  force_blocks_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_any |-> (!step_a && !step_b));

  // R9
  reset_zero_chk: assert property (@(posedge clk) !rst_n |-> (q_out == 4'b0000));

endmodule

// File: tb/biquinary_counter_bench.sv
module biquinary_counter_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       a_drv = 1'b0, b_drv = 1'b0;
  logic       wire_mode = 1'b0;
  logic       za = 1'b0, zb = 1'b0, na = 1'b0, nb = 1'b0;
  logic [3:0] q_out;
  logic       b_in;
  int         n_checks = 0;
  int         n_errors = 0;

  always #5 clk = ~clk;

  assign b_in = wire_mode ? q_out[0] : b_drv;

  biquinary_counter u_biquinary_counter (
    .clk(clk), .rst_n(rst_n), .cnt_a_in(a_drv), .cnt_b_in(b_in),
    .zero_req_a(za), .zero_req_b(zb), .nine_req_a(na), .nine_req_b(nb),
    .q_out(q_out));

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_a();
    a_drv = 1'b1; wait_n(5);
    a_drv = 1'b0; wait_n(8);
  endtask

  task automatic pulse_b();
    b_drv = 1'b1; wait_n(5);
    b_drv = 1'b0; wait_n(8);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wire_mode = 1'b0;
    a_drv = 1'b0; b_drv = 1'b0; za = 0; zb = 0; na = 0; nb = 0;
    wait_n(3);
    check("R9 reset", q_out, 4'b0000);
    rst_n = 1'b1; wait_n(2);
  endtask

  task automatic t_latency();
    do_reset();
    a_drv = 1'b1; wait_n(6);
    a_drv = 1'b0;
    wait_n(2);
    check("R10 before third edge", q_out, 4'b0000);
    wait_n(1);
    check("R10 at third edge", q_out, 4'b0001);
    wait_n(5);
  endtask

  task automatic t_div2();
    do_reset();
    for (int i = 1; i <= 4; i++) begin
      pulse_a();
      check("R2 toggle", q_out, {3'b000, 1'(i % 2)});
    end
    a_drv = 1'b1; wait_n(8);
    check("R1 rising edge ignored", q_out, 4'b0000);
    a_drv = 1'b0; wait_n(8);
    check("R1 falling edge counts", q_out, 4'b0001);
  endtask

  task automatic t_div5();
    do_reset();
    for (int i = 1; i <= 7; i++) begin
      pulse_b();
      check("R3 quinary step", q_out, {3'(i % 5), 1'b0});
    end
    b_drv = 1'b1; wait_n(8);
    check("R1 B rise ignored", q_out, {3'd2, 1'b0});
    b_drv = 1'b0; wait_n(8);
  endtask

  task automatic t_bcd();
    do_reset();
    wire_mode = 1'b1;
    for (int i = 1; i <= 25; i++) begin
      pulse_a();
      check("R4 BCD step", q_out, 4'(i % 10));
    end
    wire_mode = 1'b0;
  endtask

  task automatic t_force_table();
    do_reset();
    for (int c = 0; c < 16; c++) begin
      logic [3:0] exp;
      na = 1; nb = 1; wait_n(2);
      na = 0; nb = 0; wait_n(2);
      pulse_a();
      check("R7 preset then A fall gives 8", q_out, 4'b1000);
      {za, zb, na, nb} = 4'(c);
      wait_n(3);
      if (na && nb)      exp = 4'b1001;
      else if (za && zb) exp = 4'b0000;
      else               exp = 4'b1000;
      if (na && nb)      check("R6 nine force", q_out, exp);
      else if (za && zb) check("R5 zero force", q_out, exp);
      else               check("R7 half pair no effect", q_out, exp);
      {za, zb, na, nb} = 4'b0000;
      wait_n(2);
    end
  endtask

  task automatic t_force_ignore();
    do_reset();
    na = 1; nb = 1; wait_n(2);
    pulse_a(); pulse_b();
    na = 0; nb = 0; wait_n(8);
    check("R8 edges during nine force dropped", q_out, 4'b1001);
    za = 1; zb = 1; wait_n(2);
    pulse_a();
    za = 0; zb = 0; wait_n(8);
    check("R8 edges during zero force dropped", q_out, 4'b0000);
    pulse_a();
    check("R8 counting resumes", q_out, 4'b0001);
  endtask

  initial begin
    t_latency();
    t_div2();
    t_div5();
    t_bcd();
    t_force_table();
    t_force_ignore();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #1_000_000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule